// File: doc/BRIEF.md
# Power-Balancing Core Mode Governor

The governor sets the power mode of each core in a multi-core cluster so that the cluster stays inside a power budget while power is spread evenly across the cores. Each core runs in one of three modes: Turbo, Efficient1 or Efficient2. Once per explore interval, a tick makes the governor capture three inputs: the measured power of every core, a table of predicted power for every core in every mode, and the budget. It then runs an adjust loop. While the estimated total is above the budget, it slows down the hungriest core by one mode. While there is headroom, it speeds up the most frugal core by one mode, but only if the result still fits. The sensors and the voltage/frequency actuators sit outside the block.

The control path is a two-state machine. In `ST_IDLE` the block waits for a tick. The transition *start* (tick seen) captures the inputs and enters `ST_STEP`. In `ST_STEP` each cycle either applies exactly one legal move and stays (transition *move*), or finds no legal move, publishes the working modes with a one-cycle valid strobe and returns to `ST_IDLE` (transition *publish*). Each core has a running estimate. It starts at the core's measured power, and after each move the core's predicted power in its new mode replaces it.

Top module: `pwr_balance_gov`

## Requirements
- R1: After reset every core's mode is Turbo (all of `mode_o` is zero) and `valid_o` is low.
- R2: The mode of core i is on `mode_o[2i+1:2i]`, coded 0 = Turbo, 1 = Efficient1, 2 = Efficient2. The code 3 never appears.
- R3: While the estimated total exceeds the budget, each step moves the core with the highest estimate one mode slower. The core's estimate then becomes its predicted power in the new mode, read from `pred_pwr_i[(3i+m)*PW +: PW]` for core i and mode code m.
- R4: A core in Efficient2 is skipped when the demotion target is chosen, and the next-highest core that can still be demoted is taken. If no core can be demoted, the loop ends even though the total is still over the budget.
- R5: While the estimated total is at or below the budget, each step moves the non-Turbo core with the lowest estimate one mode faster, provided the predicted total after the move is at or below the budget.
- R6: If the chosen promotion would push the predicted total above the budget, the loop ends and no further mode changes in that interval.
- R7: Ties for the highest or the lowest estimate go to the lowest core index.
- R8: `mode_o` changes only in the cycle where `valid_o` is high. `valid_o` is high for exactly one cycle at the end of each interval's loop, even when no mode changed.
- R9: A tick that arrives while the adjust loop is running is ignored: it neither restarts the loop nor reloads the captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Explore-interval tick |
| budget_i | input | PW+log2(NCORES) | Cluster power budget |
| meas_pwr_i | input | NCORES*PW | Measured power per core, core i at bits [i*PW +: PW] |
| pred_pwr_i | input | NCORES*3*PW | Predicted power per core and mode |
| mode_o | output | 2*NCORES | Published mode per core |
| valid_o | output | 1 | One-cycle strobe when new modes are published |

## Verification
The bench drives equal-power ties. A design that breaks ties toward the wrong core would slow down core 3 instead of core 0. It drives a prediction table in which one core's power rises when it slows down, which forces the loop past a core already in Efficient2. A design without the skip would stall or code an illegal mode. Other cases are a promotion that just misses the budget, which a careless design would apply and leave the cluster over budget, and a long multi-step descent and ascent across all three modes. A second tick is fired mid-loop with a large budget. A design that reloads would end with every core in Turbo or would strobe valid twice.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    typedef enum logic [1:0] {
        MODE_TURBO = 2'd0,
        MODE_EFF1  = 2'd1,
        MODE_EFF2  = 2'd2
    } pmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } gstate_e;

    localparam int NUM_MODES = 3;

endpackage

// File: rtl/pbg_pick.sv
module pbg_pick #(
    parameter int N        = 4,
    parameter int PW       = 8,
    parameter bit FIND_MAX = 1'b1,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*PW-1:0] val_i,
    input  logic [N-1:0]    elig_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);

    logic [PW-1:0] best;

    // Strict comparison keeps the earliest index on a tie.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] &&
                (!found_o ||
                 (FIND_MAX ? (val_i[i*PW +: PW] > best) : (val_i[i*PW +: PW] < best)))) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                best    = val_i[i*PW +: PW];
            end
        end
    end

    // R4: a reported winner is always an eligible core
    always_comb begin
        if (found_o === 1'b1) begin
            a_r4_pick_eligible: assert (elig_i[idx_o] === 1'b1);
        end
    end

endmodule

// File: rtl/pbg_total.sv
module pbg_total #(
    parameter int N  = 4,
    parameter int PW = 8,
    localparam int SW = PW + ((N > 1) ? $clog2(N) : 1)
) (
    input  logic [N*PW-1:0] val_i,
    output logic [SW-1:0]   sum_o
);

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N; i++) begin
            sum_o = sum_o + SW'(val_i[i*PW +: PW]);
        end
    end

endmodule

// File: rtl/pwr_balance_gov.sv
module pwr_balance_gov
    import pbg_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int PW     = 8,
    localparam int SW    = PW + ((NCORES > 1) ? $clog2(NCORES) : 1),
    localparam int IW    = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int TW    = NCORES * NUM_MODES * PW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [SW-1:0]         budget_i,
    input  logic [NCORES*PW-1:0]  meas_pwr_i,
    input  logic [TW-1:0]         pred_pwr_i,
    output logic [2*NCORES-1:0]   mode_o,
    output logic                  valid_o
);

    gstate_e              state_q, state_d;
    logic [PW-1:0]        est_q   [NCORES];
    pmode_e               wmode_q [NCORES];
    logic [TW-1:0]        pred_q;
    logic [SW-1:0]        budget_q;
    logic [2*NCORES-1:0]  mode_q;
    logic                 valid_q;

    logic [NCORES*PW-1:0] est_flat;
    logic [2*NCORES-1:0]  wpack;
    logic [NCORES-1:0]    can_slow, can_speed;
    logic [SW-1:0]        total;
    logic                 hi_found, lo_found;
    logic [IW-1:0]        hi_idx, lo_idx;
    pmode_e               hi_next, lo_next;
    logic [PW-1:0]        hi_new, lo_new;
    logic [SW:0]          cand;
    logic                 over, do_demote, do_promote, any_move;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        assign est_flat[g*PW +: PW] = est_q[g];
        assign wpack[2*g +: 2]      = wmode_q[g];
        assign can_slow[g]          = (wmode_q[g] != MODE_EFF2);
        assign can_speed[g]         = (wmode_q[g] != MODE_TURBO);
    end

    pbg_total #(.N(NCORES), .PW(PW)) u_total (
        .val_i (est_flat),
        .sum_o (total)
    );

    pbg_pick #(.N(NCORES), .PW(PW), .FIND_MAX(1'b1)) u_pick_hi (
        .val_i   (est_flat),
        .elig_i  (can_slow),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    pbg_pick #(.N(NCORES), .PW(PW), .FIND_MAX(1'b0)) u_pick_lo (
        .val_i   (est_flat),
        .elig_i  (can_speed),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    // Candidate moves and their predicted effect.
    always_comb begin
        hi_next = (wmode_q[hi_idx] == MODE_EFF2) ? MODE_EFF2
                                                 : pmode_e'(wmode_q[hi_idx] + 2'd1);
        lo_next = (wmode_q[lo_idx] == MODE_TURBO) ? MODE_TURBO
                                                  : pmode_e'(wmode_q[lo_idx] - 2'd1);
        hi_new  = pred_q[(int'(hi_idx) * NUM_MODES + int'(hi_next)) * PW +: PW];
        lo_new  = pred_q[(int'(lo_idx) * NUM_MODES + int'(lo_next)) * PW +: PW];
        cand    = (SW+1)'(total) - (SW+1)'(est_q[lo_idx]) + (SW+1)'(lo_new);
        over       = (total > budget_q);
        do_demote  = over && hi_found;
        do_promote = !over && lo_found && (cand <= (SW+1)'(budget_q));
        any_move   = do_demote || do_promote;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: start / move / publish.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick_i)    state_d = ST_STEP;
            ST_STEP: if (!any_move) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Working state: capture on start, one move per step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCORES; i++) begin
                est_q[i]   <= '0;
                wmode_q[i] <= MODE_TURBO;
            end
            pred_q   <= '0;
            budget_q <= '0;
        end else if (state_q == ST_IDLE && tick_i) begin
            for (int i = 0; i < NCORES; i++) est_q[i] <= meas_pwr_i[i*PW +: PW];
            pred_q   <= pred_pwr_i;
            budget_q <= budget_i;
        end else if (state_q == ST_STEP) begin
            if (do_demote) begin
                wmode_q[hi_idx] <= hi_next;
                est_q[hi_idx]   <= hi_new;
            end else if (do_promote) begin
                wmode_q[lo_idx] <= lo_next;
                est_q[lo_idx]   <= lo_new;
            end
        end
    end

    // Outputs: published together with a one-cycle strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_q == ST_STEP) && !any_move;
            if (state_q == ST_STEP && !any_move) mode_q <= wpack;
        end
    end

    assign mode_o  = mode_q;
    assign valid_o = valid_q;

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(mode_q));

    a_r5_promote_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && do_promote) |=> (total <= budget_q));

    a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> ($stable(budget_q) && $stable(pred_q)));

    for (genvar g = 0; g < NCORES; g++) begin : g_chk
        a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[2*g +: 2] != 2'd3);
    end

endmodule

// File: tb/pwr_balance_gov_test.sv
module pwr_balance_gov_test;

    localparam int N  = 4;
    localparam int PW = 8;
    localparam int SW = PW + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [SW-1:0]     budget = '0;
    logic [N*PW-1:0]   meas_v = '0;
    logic [N*3*PW-1:0] pred_v = '0;
    logic [2*N-1:0]    mode_o;
    logic              valid_o;

    int meas[N];
    int pt[N];
    int pe1[N];
    int pe2[N];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_balance_gov #(.NCORES(N), .PW(PW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .budget_i   (budget),
        .meas_pwr_i (meas_v),
        .pred_pwr_i (pred_v),
        .mode_o     (mode_o),
        .valid_o    (valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pack_inputs();
        for (int i = 0; i < N; i++) begin
            meas_v[i*PW +: PW]       = PW'(meas[i]);
            pred_v[(3*i+0)*PW +: PW] = PW'(pt[i]);
            pred_v[(3*i+1)*PW +: PW] = PW'(pe1[i]);
            pred_v[(3*i+2)*PW +: PW] = PW'(pe2[i]);
        end
    endtask

    task automatic default_preds();
        for (int i = 0; i < N; i++) begin
            pt[i] = 100; pe1[i] = 70; pe2[i] = 50;
        end
    endtask

    // One explore interval; optionally a second tick mid-loop (R9).
    task automatic run_interval(input int bud, input logic [7:0] exp,
                                input string req, input bit extra);
        logic [7:0] prior;
        bit seen;
        int pulses;
        pack_inputs();
        budget = SW'(bud);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        prior = mode_o;
        seen = 1'b0;
        for (int c = 0; c < 60 && !seen; c++) begin
            @(negedge clk);
            if (extra && c == 1) begin tick = 1'b1; budget = '1; end
            if (extra && c == 2) tick = 1'b0;
            if (valid_o) seen = 1'b1;
            else if (mode_o != prior)
                check(1'b0, "R8 mode changed without valid", int'(mode_o), int'(prior));
        end
        check(seen, "R8 valid strobe seen", int'(seen), 1);
        check(mode_o == exp, req, int'(mode_o), int'(exp));
        @(negedge clk);
        check(!valid_o, "R8 valid lasts one cycle", int'(valid_o), 0);
        if (extra) begin
            pulses = 0;
            for (int c = 0; c < 15; c++) begin
                @(negedge clk);
                if (valid_o) pulses++;
            end
            check(pulses == 0, "R9 mid-loop tick ignored", pulses, 0);
            check(mode_o == exp, "R9 modes kept", int'(mode_o), int'(exp));
        end
    endtask

    task automatic t_reset();
        check(mode_o == 8'h00, "R1 reset modes Turbo", int'(mode_o), 0);
        check(!valid_o, "R1 reset valid low", int'(valid_o), 0);
    endtask

    task automatic t_overshoot();
        pt  = '{90, 120, 80, 100};
        for (int i = 0; i < N; i++) begin
            pe1[i] = pt[i] - 30; pe2[i] = pt[i] - 50; meas[i] = pt[i];
        end
        run_interval(380, 8'h04, "R3 highest core slowed, R6 re-promote refused", 1'b0);
    endtask

    task automatic t_tight_promote();
        meas[1] = 90;
        run_interval(380, 8'h04, "R6 promotion over budget not applied", 1'b0);
    endtask

    task automatic t_promote();
        run_interval(400, 8'h00, "R5 lowest core sped up", 1'b0);
    endtask

    task automatic t_tie();
        default_preds();
        meas = '{100, 100, 100, 100};
        run_interval(370, 8'h01, "R7 tie demotes core 0", 1'b0);
    endtask

    task automatic t_deep_busy();
        meas = '{70, 100, 100, 100};
        run_interval(200, 8'hAA, "R3 R7 multi-step descent to Efficient2", 1'b1);
    endtask

    task automatic t_none_demotable();
        meas = '{50, 50, 50, 50};
        run_interval(150, 8'hAA, "R4 no demotable core, loop ends", 1'b0);
    endtask

    task automatic t_climb();
        run_interval(500, 8'h00, "R5 multi-step climb to Turbo", 1'b0);
    endtask

    task automatic t_skip_eff2();
        default_preds();
        pe1[0] = 120; pe2[0] = 150;
        meas = '{100, 100, 100, 100};
        run_interval(370, 8'h56, "R4 Efficient2 core skipped, R2 encoding", 1'b0);
    endtask

    initial begin
        default_preds();
        meas = '{0, 0, 0, 0};
        pack_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_overshoot();
        t_tight_promote();
        t_promote();
        t_tie();
        t_deep_busy();
        t_none_demotable();
        t_climb();
        t_skip_eff2();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule